// File: doc/BRIEF.md
# Three-Stage Interlocked Pipeline Core

A small in-order processor core whose instructions pass through three stages: fetch, execute and commit. In the fetch stage the instruction word is read from an internal instruction memory. In the execute stage the source operand is read and the result or branch decision is computed. In the commit stage the result is written into the register file or the data memory. Without hazards, one instruction enters the pipeline and one leaves it every clock, so three are in flight at once.

The core has no bypass network. An instruction in execute that reads the register being written by the instruction in the commit stage stalls for one cycle, and a no-op bubble goes forward in its place. There is no branch prediction. Once a branch has been fetched, fetch freezes until the branch resolves in execute, and then restarts at the correct address with an empty pipeline.

Both memories are preloaded through dedicated write ports while reset is held. When the core reaches a halt, it stops fetching and raises `done` once the pipeline is empty. The register file and the data memory can then be inspected through two combinational read ports.

Top module: `pipe3_core`

## Requirements
- R1: With no hazards, a program of k instructions followed by a halt raises `done` after exactly k+2 rising edges following reset release.
- R2: The instruction word has the opcode in [15:13], the destination register rd in [12:11], the source register rs in [10:9] and the immediate or address in [8:0]. The opcodes are: 1 loads the immediate into rd; 2 copies rs into rd; 3 adds the immediate to rd; 4 writes rs to data address imm; 5 branches to imm if rs is zero; 7 halts; 0 and 6 do nothing.
- R3: When the instruction in execute reads a register that the valid instruction in the commit stage is about to write, it stalls for exactly one cycle, and the value it then uses is the committed one.
- R4: During a stall, the instruction held between fetch and execute does not change, and no new instruction is fetched.
- R5: After a branch is fetched, nothing more is fetched until the branch resolves. A taken branch resumes at its target and a not-taken branch at the next word. Each resolution costs one empty fetch slot, and instructions that were skipped have no effect.
- R6: After a halt is fetched, no further instruction is fetched. `done` rises once the pipeline is empty and stays high until reset.
- R7: A stall bubble writes neither a register nor memory, and the cycle after a stall has no valid instruction in the commit stage.
- R8: A synchronous active-low reset clears all four registers, the program counter, every pipeline valid bit and `done`.
- R9: The preload ports write the instruction and data memories. The read ports return register `dbg_reg_sel` and data word `dbg_dmem_addr` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_imem_we | input | 1 | Instruction memory preload write enable |
| ld_imem_addr | input | IAW (6) | Instruction memory preload address |
| ld_imem_data | input | 16 | Instruction word to preload |
| ld_dmem_we | input | 1 | Data memory preload write enable |
| ld_dmem_addr | input | DAW (6) | Data memory preload address |
| ld_dmem_data | input | DW (8) | Data word to preload |
| dbg_dmem_addr | input | DAW (6) | Data memory inspection address |
| dbg_dmem_data | output | DW (8) | Data word at `dbg_dmem_addr` |
| dbg_reg_sel | input | 2 | Register inspection select |
| dbg_reg_data | output | DW (8) | Contents of the selected register |
| done | output | 1 | High when halted and the pipeline is empty |

## Verification
Four program shapes are used. A run of independent loads followed by stores tells a full-rate pipeline apart from one that stalls when it should not. A chain of dependent moves, adds and stores tells a correct single-cycle interlock apart from a missing one, which gives stale values, or an excessive one, which gives a longer run time. A pair of branches, one taken and one not, tells proper fetch freezing and redirection apart from wrong-path execution, since a skipped load would otherwise change a register. A reset applied after a run shows that the registers and `done` are cleared.

// File: rtl/pipe3_pkg.sv
// Shared opcode and field definitions for the three-stage core.
// Assumes a 16-bit instruction word: op[15:13] rd[12:11] rs[10:9] imm[8:0].
package pipe3_pkg;
    localparam int IW   = 16;
    localparam int RAW  = 2;
    localparam int IMMW = 9;

    localparam logic [2:0] OP_NOP   = 3'd0;
    localparam logic [2:0] OP_LDI   = 3'd1;
    localparam logic [2:0] OP_MOV   = 3'd2;
    localparam logic [2:0] OP_ADDI  = 3'd3;
    localparam logic [2:0] OP_STORE = 3'd4;
    localparam logic [2:0] OP_BEQZ  = 3'd5;
    localparam logic [2:0] OP_HALT  = 3'd7;

    function automatic logic [2:0] f_op(input logic [IW-1:0] w);
        return w[15:13];
    endfunction

    function automatic logic [RAW-1:0] f_rd(input logic [IW-1:0] w);
        return w[12:11];
    endfunction

    function automatic logic [RAW-1:0] f_rs(input logic [IW-1:0] w);
        return w[10:9];
    endfunction

    function automatic logic [IMMW-1:0] f_imm(input logic [IW-1:0] w);
        return w[8:0];
    endfunction
endpackage

// File: rtl/pipe3_fetch.sv
// Fetch stage: holds the program counter and the instruction memory, and
// loads the fetch/execute register. Stops fetching while a stall is active,
// while a fetched branch is unresolved, and for good once a halt is fetched.
// Assumes a redirect arrives only while a branch hold is pending.
module pipe3_fetch
    import pipe3_pkg::*;
#(
    parameter int IAW = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_we,
    input  logic [IAW-1:0] ld_addr,
    input  logic [IW-1:0]  ld_data,
    input  logic           stall,
    input  logic           redirect,
    input  logic           redirect_taken,
    input  logic [IAW-1:0] redirect_pc,
    output logic           fe_valid,
    output logic [IW-1:0]  fe_instr,
    output logic           halted
);
    localparam int             DEPTH = 1 << IAW;
    localparam logic [IAW-1:0] PC_ONE = 1;

    logic [IW-1:0]  imem [DEPTH];
    logic [IAW-1:0] pc;
    logic           hold;
    logic [IW-1:0]  word;
    logic           fetch_en;

    assign word     = imem[pc];
    assign fetch_en = !stall && !hold && !halted;

    // Instruction memory preload write.
    always_ff @(posedge clk) begin
        if (ld_we) imem[ld_addr] <= ld_data;
    end

    // Program counter, branch hold, halt latch and fetch/execute register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc       <= '0;
            hold     <= 1'b0;
            halted   <= 1'b0;
            fe_valid <= 1'b0;
            fe_instr <= '0;
        end else begin
            if (redirect) begin
                hold <= 1'b0;
                if (redirect_taken) pc <= redirect_pc;
            end
            if (!stall) begin
                if (fetch_en) begin
                    fe_instr <= word;
                    fe_valid <= 1'b1;
                    pc       <= pc + PC_ONE;
                    if (f_op(word) == OP_BEQZ) hold   <= 1'b1;
                    if (f_op(word) == OP_HALT) halted <= 1'b1;
                end else begin
                    fe_valid <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/pipe3_exec.sv
// Execute stage: detects the interlock against the commit stage, computes
// results and branch decisions, and loads the execute/commit register.
// Assumes a single source operand per instruction (rd for add, rs otherwise).
module pipe3_exec
    import pipe3_pkg::*;
#(
    parameter int IAW = 6,
    parameter int DAW = 6,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           fe_valid,
    input  logic [IW-1:0]  fe_instr,
    output logic [RAW-1:0] src_sel,
    input  logic [DW-1:0]  src_val,
    output logic           stall,
    output logic           redirect,
    output logic           redirect_taken,
    output logic [IAW-1:0] redirect_pc,
    output logic           s_valid,
    output logic           s_wr_reg,
    output logic           s_wr_mem,
    output logic [RAW-1:0] s_rd,
    output logic [DAW-1:0] s_addr,
    output logic [DW-1:0]  s_val
);
    logic [2:0]      op;
    logic [IMMW-1:0] imm;
    logic            reads_rs, reads_rd, needs_src, writes_reg, active;
    logic [DW-1:0]   result;
    logic            unused_imm;

    assign op         = f_op(fe_instr);
    assign imm        = f_imm(fe_instr);
    assign unused_imm = ^imm;
    assign reads_rs   = (op == OP_MOV) || (op == OP_STORE) || (op == OP_BEQZ);
    assign reads_rd   = (op == OP_ADDI);
    assign needs_src  = fe_valid && (reads_rs || reads_rd);
    assign src_sel    = reads_rd ? f_rd(fe_instr) : f_rs(fe_instr);
    assign writes_reg = (op == OP_LDI) || (op == OP_MOV) || (op == OP_ADDI);
    assign active     = writes_reg || (op == OP_STORE);

    // Interlock: the source is still being written by the commit stage.
    assign stall = needs_src && s_valid && s_wr_reg && (s_rd == src_sel);

    // Branch resolution.
    assign redirect       = fe_valid && (op == OP_BEQZ) && !stall;
    assign redirect_taken = (src_val == '0);
    assign redirect_pc    = imm[IAW-1:0];

    // Result selection per opcode.
    always_comb begin
        case (op)
            OP_LDI:  result = imm[DW-1:0];
            OP_ADDI: result = src_val + imm[DW-1:0];
            default: result = src_val;
        endcase
    end

    // Execute/commit register; a stall or non-writing opcode becomes a bubble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid  <= 1'b0;
            s_wr_reg <= 1'b0;
            s_wr_mem <= 1'b0;
            s_rd     <= '0;
            s_addr   <= '0;
            s_val    <= '0;
        end else begin
            s_valid  <= fe_valid && !stall && active;
            s_wr_reg <= writes_reg;
            s_wr_mem <= (op == OP_STORE);
            s_rd     <= f_rd(fe_instr);
            s_addr   <= imm[DAW-1:0];
            s_val    <= result;
        end
    end
endmodule

// File: rtl/pipe3_commit.sv
// Commit stage: register file and data memory. Writes happen at the edge that
// ends the commit cycle; reads are combinational. Preload writes take priority.
module pipe3_commit
    import pipe3_pkg::*;
#(
    parameter int DAW = 6,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           s_valid,
    input  logic           s_wr_reg,
    input  logic           s_wr_mem,
    input  logic [RAW-1:0] s_rd,
    input  logic [DAW-1:0] s_addr,
    input  logic [DW-1:0]  s_val,
    input  logic [RAW-1:0] src_sel,
    output logic [DW-1:0]  src_val,
    input  logic           ld_we,
    input  logic [DAW-1:0] ld_addr,
    input  logic [DW-1:0]  ld_data,
    input  logic [DAW-1:0] dbg_addr,
    output logic [DW-1:0]  dbg_data,
    input  logic [RAW-1:0] dbg_sel,
    output logic [DW-1:0]  dbg_reg
);
    localparam int NREG  = 1 << RAW;
    localparam int DEPTH = 1 << DAW;

    logic [DW-1:0] regs [NREG];
    logic [DW-1:0] dmem [DEPTH];

    assign src_val  = regs[src_sel];
    assign dbg_reg  = regs[dbg_sel];
    assign dbg_data = dmem[dbg_addr];

    // Register file with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (s_valid && s_wr_reg) begin
            regs[s_rd] <= s_val;
        end
    end

    // Data memory: preload first, otherwise committed stores.
    always_ff @(posedge clk) begin
        if (ld_we) dmem[ld_addr] <= ld_data;
        else if (rst_n && s_valid && s_wr_mem) dmem[s_addr] <= s_val;
    end
endmodule

// File: rtl/pipe3_core.sv
// Top of the three-stage interlocked core: connects fetch, execute and commit
// and produces done. Assumes memories are preloaded while rst_n is low.
module pipe3_core
    import pipe3_pkg::*;
#(
    parameter int IAW = 6,
    parameter int DAW = 6,
    parameter int DW  = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ld_imem_we,
    input  logic [IAW-1:0] ld_imem_addr,
    input  logic [IW-1:0]  ld_imem_data,
    input  logic           ld_dmem_we,
    input  logic [DAW-1:0] ld_dmem_addr,
    input  logic [DW-1:0]  ld_dmem_data,
    input  logic [DAW-1:0] dbg_dmem_addr,
    output logic [DW-1:0]  dbg_dmem_data,
    input  logic [RAW-1:0] dbg_reg_sel,
    output logic [DW-1:0]  dbg_reg_data,
    output logic           done
);
    logic           fe_valid, halted, stall;
    logic [IW-1:0]  fe_instr;
    logic           redirect, redirect_taken;
    logic [IAW-1:0] redirect_pc;
    logic [RAW-1:0] src_sel;
    logic [DW-1:0]  src_val;
    logic           s_valid, s_wr_reg, s_wr_mem;
    logic [RAW-1:0] s_rd;
    logic [DAW-1:0] s_addr;
    logic [DW-1:0]  s_val;

    assign done = halted && !fe_valid && !s_valid;

    pipe3_fetch #(.IAW(IAW)) u_fetch (
        .clk(clk), .rst_n(rst_n),
        .ld_we(ld_imem_we), .ld_addr(ld_imem_addr), .ld_data(ld_imem_data),
        .stall(stall), .redirect(redirect), .redirect_taken(redirect_taken),
        .redirect_pc(redirect_pc), .fe_valid(fe_valid), .fe_instr(fe_instr),
        .halted(halted)
    );

    pipe3_exec #(.IAW(IAW), .DAW(DAW), .DW(DW)) u_exec (
        .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_instr(fe_instr),
        .src_sel(src_sel), .src_val(src_val), .stall(stall),
        .redirect(redirect), .redirect_taken(redirect_taken),
        .redirect_pc(redirect_pc), .s_valid(s_valid), .s_wr_reg(s_wr_reg),
        .s_wr_mem(s_wr_mem), .s_rd(s_rd), .s_addr(s_addr), .s_val(s_val)
    );

    pipe3_commit #(.DAW(DAW), .DW(DW)) u_commit (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_wr_reg(s_wr_reg),
        .s_wr_mem(s_wr_mem), .s_rd(s_rd), .s_addr(s_addr), .s_val(s_val),
        .src_sel(src_sel), .src_val(src_val),
        .ld_we(ld_dmem_we), .ld_addr(ld_dmem_addr), .ld_data(ld_dmem_data),
        .dbg_addr(dbg_dmem_addr), .dbg_data(dbg_dmem_data),
        .dbg_sel(dbg_reg_sel), .dbg_reg(dbg_reg_data)
    );
endmodule

// File: rtl/pipe3_core_chk.sv
// Checker for pipe3_core: pipeline-control properties, bound to the top.
module pipe3_core_chk
    import pipe3_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          fe_valid,
    input logic [IW-1:0] fe_instr,
    input logic          stall,
    input logic          s_valid,
    input logic          done
);
    AST_STALL_HOLDS_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ($stable(fe_instr) && fe_valid)); // R4

    AST_STALL_MAKES_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !s_valid); // R7

    AST_BRANCH_FREEZES_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (fe_valid && f_op(fe_instr) == OP_BEQZ && !stall) |=> !fe_valid); // R5

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done); // R6

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!fe_valid && !s_valid && !done)); // R8
endmodule

bind pipe3_core pipe3_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .fe_valid(fe_valid), .fe_instr(fe_instr),
    .stall(stall), .s_valid(s_valid), .done(done)
);

// File: tb/sim_pipe3_core.sv
`timescale 1ns/1ps
// Bench for pipe3_core: loads programs during reset, times the run to done,
// then compares registers and memory with expectations from the requirements.
module sim_pipe3_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ld_imem_we = 1'b0;
    logic [5:0] ld_imem_addr = '0;
    logic [15:0] ld_imem_data = '0;
    logic       ld_dmem_we = 1'b0;
    logic [5:0] ld_dmem_addr = '0;
    logic [7:0] ld_dmem_data = '0;
    logic [5:0] dbg_dmem_addr = '0;
    logic [7:0] dbg_dmem_data;
    logic [1:0] dbg_reg_sel = '0;
    logic [7:0] dbg_reg_data;
    logic       done;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pipe3_core u0 (
        .clk(clk), .rst_n(rst_n),
        .ld_imem_we(ld_imem_we), .ld_imem_addr(ld_imem_addr), .ld_imem_data(ld_imem_data),
        .ld_dmem_we(ld_dmem_we), .ld_dmem_addr(ld_dmem_addr), .ld_dmem_data(ld_dmem_data),
        .dbg_dmem_addr(dbg_dmem_addr), .dbg_dmem_data(dbg_dmem_data),
        .dbg_reg_sel(dbg_reg_sel), .dbg_reg_data(dbg_reg_data), .done(done)
    );

    function automatic logic [15:0] enc(input int op, input int rd, input int rs, input int imm);
        return {op[2:0], rd[1:0], rs[1:0], imm[8:0]};
    endfunction

    // Expected results of program one: {is_mem, address, value}.
    localparam logic [14:0] EXP1 [6] = '{
        {1'b0, 6'd0, 8'd40}, {1'b0, 6'd1, 8'd60}, {1'b0, 6'd2, 8'd8},
        {1'b0, 6'd3, 8'd0},  {1'b1, 6'd5, 8'd60}, {1'b1, 6'd6, 8'd8}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [15:0] w);
        @(negedge clk);
        ld_imem_we = 1'b1; ld_imem_addr = a[5:0]; ld_imem_data = w;
        @(negedge clk);
        ld_imem_we = 1'b0;
    endtask

    task automatic put_data(input int a, input int v);
        @(negedge clk);
        ld_dmem_we = 1'b1; ld_dmem_addr = a[5:0]; ld_dmem_data = v[7:0];
        @(negedge clk);
        ld_dmem_we = 1'b0;
    endtask

    // Release reset and count rising edges until done is seen.
    task automatic run(output int cyc);
        cyc = 0;
        @(negedge clk);
        rst_n = 1'b1;
        while (cyc < 500) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done) break;
        end
        if (!done) check(1'b0, "watchdog", cyc, 0);
    endtask

    function automatic int rdreg(input int r);
        return 0;
    endfunction

    task automatic get_reg(input int r, output int v);
        dbg_reg_sel = r[1:0]; #1; v = dbg_reg_data;
    endtask

    task automatic get_mem(input int a, output int v);
        dbg_dmem_addr = a[5:0]; #1; v = dbg_dmem_data;
    endtask

    initial begin
        int cyc, v;
        // Reset state.
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8 done in reset", done, 0);
        get_reg(1, v);
        check(v == 0, "R8 reg clear", v, 0);

        // Program one: dependent chain, four interlocks (R3, R2).
        put(0, enc(1, 0, 0, 40));
        put(1, enc(2, 1, 0, 0));
        put(2, enc(3, 1, 0, 20));
        put(3, enc(4, 0, 1, 5));
        put(4, enc(1, 2, 0, 7));
        put(5, enc(1, 3, 0, 0));
        put(6, enc(3, 2, 0, 1));
        put(7, enc(4, 0, 2, 6));
        put(8, enc(7, 0, 0, 0));
        put_data(6, 200);
        put_data(9, 77);
        run(cyc);
        check(cyc == 14, "R3 interlock cycles", cyc, 14);
        for (int i = 0; i < 6; i++) begin
            if (EXP1[i][14]) get_mem(int'(EXP1[i][13:8]), v);
            else get_reg(int'(EXP1[i][13:8]), v);
            check(v == int'(EXP1[i][7:0]), "R2 R3 result", v, int'(EXP1[i][7:0]));
        end
        get_mem(9, v);
        check(v == 77, "R9 preload kept, R7 no stray write", v, 77);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R6 done sticky", done, 1);

        // Reset after a run clears state.
        rst_n = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R8 done cleared", done, 0);
        get_reg(0, v);
        check(v == 0, "R8 r0 cleared", v, 0);

        // Program two: no hazards, full rate (R1).
        put(0, enc(1, 0, 0, 1));
        put(1, enc(1, 1, 0, 2));
        put(2, enc(1, 2, 0, 3));
        put(3, enc(1, 3, 0, 4));
        put(4, enc(4, 0, 0, 0));
        put(5, enc(4, 0, 1, 1));
        put(6, enc(7, 0, 0, 0));
        run(cyc);
        check(cyc == 8, "R1 full rate cycles", cyc, 8);
        get_mem(0, v);
        check(v == 1, "R1 store r0", v, 1);
        get_mem(1, v);
        check(v == 2, "R1 store r1", v, 2);
        get_reg(3, v);
        check(v == 4, "R1 r3", v, 4);
        rst_n = 1'b0;

        // Program three: taken then not-taken branch (R5).
        put(0, enc(1, 0, 0, 0));
        put(1, enc(1, 1, 0, 5));
        put(2, enc(5, 0, 0, 5));
        put(3, enc(1, 1, 0, 99));
        put(4, enc(7, 0, 0, 0));
        put(5, enc(5, 0, 1, 3));
        put(6, enc(4, 0, 1, 2));
        put(7, enc(7, 0, 0, 0));
        run(cyc);
        check(cyc == 9, "R5 branch cycles", cyc, 9);
        get_reg(1, v);
        check(v == 5, "R5 skipped load no effect", v, 5);
        get_mem(2, v);
        check(v == 5, "R5 not-taken falls through", v, 5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Global watchdog.
    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule